// File: doc/BRIEF.md
# Multi-dimensional matrix index remapper

This block produces a stream of element offsets that presents a flat vector as a 1D, 2D or 3D array. It holds three nested dimension counters. The x counter is the innermost and moves on every step. The y counter moves when x wraps. The z counter is the outermost and moves when x and y wrap together. On each cycle the three counter values are folded into one offset. A programmable permutation sets the order in which the axes are stacked. Each axis can run in reverse. One stacked position can be left out of the offset while its counter still runs. A base value is added to the result. Three loop-end flags go with every offset.

The shape configuration is loaded by pulsing `restart`. After that, each cycle with `step` high uses up the current offset and moves to the next one. The schedule wraps around with no end, so running a multiple of the element count repeats the same pattern. This makes it possible to read a non-power-of-two matrix in transposed or mirrored order in place. The configuration must stay stable between restarts. The product of the three sizes is expected to be 127 or less.

Top module: `mdim_remap`

## Requirements
- R1: The counters nest with z outermost and x innermost. x advances on every step. y advances only on a step where x is at its last value. z advances only on a step where x and y are both at their last values.
- R2: Each bit of `invert` (bit 0 for x, bit 1 for y, bit 2 for z) makes that counter start at size-1 and count down to 0, then wrap back to size-1. When the bit is clear the counter starts at 0 and counts up to size-1.
- R3: `order0`, `order1` and `order2` name the axes stacked in positions 0, 1 and 2 of the offset. The code is 0 for x, 1 for y and 2 for z. Code 3 is treated as x.
- R4: The offset is the sum over the stacked positions of counter × (product of the sizes of the axes already stacked before that position). Position 0 has a multiplier of 1.
- R5: A `skip` code k of 1, 2 or 3 removes stacked position k-1 from both the sum and the multiplier product. That axis still counts. A code of 0 removes nothing.
- R6: `base` is added to every offset. `idx` is the result modulo 2^IDX_W.
- R7: `loop_end[0]` is set when x is at its last value. `loop_end[1]` is set when x and y are both at their last values. `loop_end[2]` is set when all three are at their last values.
- R8: After the last element the schedule wraps to its first element and repeats the same sequence endlessly.
- R9: Each size field takes a value from 1 to 64. A size of 1 keeps that counter at 0.
- R10: On a cycle with `step` low and `restart` low, the counters and therefore `idx` and `loop_end` keep their values.
- R11: `restart` loads every counter with its starting value (from R2), and it overrides `step` in the same cycle.
- R12: While `rst_n` is low and after it is released, all counters are 0, so `idx` equals `base`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Load starting counter values |
| step | input | 1 | Advance to the next element |
| size_x | input | DIM_W | x dimension size, 1..64 |
| size_y | input | DIM_W | y dimension size, 1..64 |
| size_z | input | DIM_W | z dimension size, 1..64 |
| order0 | input | 2 | Axis stacked first (0=x,1=y,2=z) |
| order1 | input | 2 | Axis stacked second |
| order2 | input | 2 | Axis stacked third |
| invert | input | 3 | Per-axis reversal, bit0=x, bit1=y, bit2=z |
| skip | input | 2 | Stacked position to omit (0=none) |
| base | input | BASE_W | Offset added to every index |
| idx | output | IDX_W | Remapped element offset |
| loop_end | output | 3 | Loop-end flags |

## Verification
The counters are the only registers. `idx` and `loop_end` are combinational from the counters and the configuration. A `step` or `restart` sampled at one rising edge therefore shows up on the outputs right after that same edge, with zero added latency. The bench drives inputs just after the falling edge. It updates its behavioural counter model on the rising edge, using the same inputs the design sees. It compares `idx` and `loop_end` at the next falling edge, which is one full register stage after the stimulus. Stalls from a random `step`, a restart that overrides a step, and long wraps are all checked in this same per-cycle window.

// File: rtl/remap_pkg.sv
// Shared constants for the matrix index remapper.
// Assumes exactly three nested dimensions.
package remap_pkg;
    localparam int NDIM = 3;
    // Axis codes used by the order fields.
    localparam logic [1:0] AXIS_X = 2'd0;
    localparam logic [1:0] AXIS_Y = 2'd1;
    localparam logic [1:0] AXIS_Z = 2'd2;
endpackage

// File: rtl/dim_counter.sv
// One wrapping dimension counter.
// Counts 0..size-1 upward, or size-1..0 when inverted. Flags its last value.
// Assumes size >= 1 and that size/invert are stable between restarts.
module dim_counter #(
    parameter int DIM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [DIM_W-1:0] size,
    input  logic             invert,
    output logic [DIM_W-1:0] count,
    output logic             at_last
);
    logic [DIM_W-1:0] top_val;
    logic [DIM_W-1:0] start_val;

    // Derive the highest value and the starting value from size and direction.
    always_comb begin
        top_val   = size - 1'b1;
        start_val = invert ? top_val : '0;
        at_last   = invert ? (count == '0) : (count == top_val);
    end

    // Step, wrap or reload the counter; restart has priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= start_val;
        end else if (advance) begin
            if (at_last)     count <= start_val;
            else if (invert) count <= count - 1'b1;
            else             count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/index_combiner.sv
// Folds three counter values into one offset under a stacking permutation,
// an optional skipped position and a base offset.
// Assumes IDX_W >= DIM_W; arithmetic wraps modulo 2**IDX_W.
module index_combiner
    import remap_pkg::*;
#(
    parameter int DIM_W  = 7,
    parameter int BASE_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic [DIM_W-1:0]  cnt   [NDIM],
    input  logic [DIM_W-1:0]  size  [NDIM],
    input  logic [1:0]        order [NDIM],
    input  logic [1:0]        skip,
    input  logic [BASE_W-1:0] base,
    output logic [IDX_W-1:0]  idx
);
    logic [DIM_W-1:0] sel_cnt  [NDIM];
    logic [DIM_W-1:0] sel_size [NDIM];

    // Route the counter and size named by each stacked position (R3).
    for (genvar p = 0; p < NDIM; p++) begin : g_pos
        always_comb begin
            unique case (order[p])
                AXIS_Y:  begin sel_cnt[p] = cnt[1]; sel_size[p] = size[1]; end
                AXIS_Z:  begin sel_cnt[p] = cnt[2]; sel_size[p] = size[2]; end
                default: begin sel_cnt[p] = cnt[0]; sel_size[p] = size[0]; end
            endcase
        end
    end

    logic [IDX_W-1:0] acc;
    logic [IDX_W-1:0] mult;

    // Sum counters weighted by the running size product, honouring skip (R4, R5, R6).
    always_comb begin
        acc  = '0;
        mult = IDX_W'(1);
        for (int p = 0; p < NDIM; p++) begin
            if (skip != 2'(p + 1)) begin
                acc  = acc + IDX_W'(sel_cnt[p]) * mult;
                mult = mult * IDX_W'(sel_size[p]);
            end
        end
        idx = acc + IDX_W'(base);
    end
endmodule

// File: rtl/mdim_remap.sv
// Top of the matrix index remapper: three nested dimension counters plus
// the offset combiner. Outputs are combinational from counter state.
// Assumes configuration is held stable between restart pulses.
module mdim_remap
    import remap_pkg::*;
#(
    parameter int DIM_W  = 7,
    parameter int BASE_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [DIM_W-1:0]  size_x,
    input  logic [DIM_W-1:0]  size_y,
    input  logic [DIM_W-1:0]  size_z,
    input  logic [1:0]        order0,
    input  logic [1:0]        order1,
    input  logic [1:0]        order2,
    input  logic [2:0]        invert,
    input  logic [1:0]        skip,
    input  logic [BASE_W-1:0] base,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        loop_end
);
    logic [DIM_W-1:0] size_a  [NDIM];
    logic [1:0]       order_a [NDIM];
    logic [DIM_W-1:0] cnt     [NDIM];
    logic [NDIM-1:0]  last;
    logic [NDIM-1:0]  adv;

    // Gather configuration into arrays indexed by axis / position.
    always_comb begin
        size_a[0]  = size_x;
        size_a[1]  = size_y;
        size_a[2]  = size_z;
        order_a[0] = order0;
        order_a[1] = order1;
        order_a[2] = order2;
    end

    // Nest the counters: each moves when the step reaches every inner wrap (R1).
    always_comb begin
        adv[0] = step;
        for (int d = 1; d < NDIM; d++) adv[d] = adv[d-1] & last[d-1];
    end

    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        dim_counter #(.DIM_W(DIM_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .advance (adv[d]),
            .size    (size_a[d]),
            .invert  (invert[d]),
            .count   (cnt[d]),
            .at_last (last[d])
        );
    end

    // Loop-end flags accumulate inner-to-outer (R7).
    always_comb begin
        loop_end[0] = last[0];
        loop_end[1] = last[0] & last[1];
        loop_end[2] = last[0] & last[1] & last[2];
    end

    index_combiner #(.DIM_W(DIM_W), .BASE_W(BASE_W), .IDX_W(IDX_W)) u_comb (
        .cnt   (cnt),
        .size  (size_a),
        .order (order_a),
        .skip  (skip),
        .base  (base),
        .idx   (idx)
    );
endmodule

// File: rtl/remap_chk.sv
// Temporal checks for the matrix index remapper, bound onto mdim_remap.
module remap_chk #(
    parameter int DIM_W  = 7,
    parameter int BASE_W = 8,
    parameter int IDX_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              step,
    input logic [2:0]        invert,
    input logic [2:0]        loop_end,
    input logic [DIM_W-1:0]  cnt_x,
    input logic [DIM_W-1:0]  cnt_y,
    input logic [DIM_W-1:0]  cnt_z
);
    a_r7_mid_needs_inner: assert property (@(posedge clk) disable iff (!rst_n)
        loop_end[1] |-> loop_end[0]);

    a_r7_top_needs_mid: assert property (@(posedge clk) disable iff (!rst_n)
        loop_end[2] |-> loop_end[1]);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> ($stable(cnt_x) && $stable(cnt_y) && $stable(cnt_z)));

    a_r1_outer_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !loop_end[0]) |=> ($stable(cnt_y) && $stable(cnt_z)));

    a_r11_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && invert == 3'b000) |=> (cnt_x == '0 && cnt_y == '0 && cnt_z == '0));
endmodule

bind mdim_remap remap_chk #(.DIM_W(DIM_W), .BASE_W(BASE_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .step     (step),
    .invert   (invert),
    .loop_end (loop_end),
    .cnt_x    (cnt[0]),
    .cnt_y    (cnt[1]),
    .cnt_z    (cnt[2])
);

// File: tb/sim_mdim_remap.sv
`timescale 1ns/1ps
module sim_mdim_remap;
    localparam int DIM_W = 7, BASE_W = 8, IDX_W = 10;

    logic clk = 0, rst_n = 0, restart = 0, step = 0;
    logic [DIM_W-1:0] size_x = 1, size_y = 1, size_z = 1;
    logic [1:0] order0 = 0, order1 = 1, order2 = 2, skip = 0;
    logic [2:0] invert = 0;
    logic [BASE_W-1:0] base = 8'd5;
    logic [IDX_W-1:0] idx;
    logic [2:0] loop_end;

    int checks = 0, failures = 0, cycles = 0;
    int mc[3];
    string tag = "R12";

    always #2.5 clk = ~clk;

    mdim_remap #(.DIM_W(DIM_W), .BASE_W(BASE_W), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .size_x(size_x), .size_y(size_y), .size_z(size_z),
        .order0(order0), .order1(order1), .order2(order2),
        .invert(invert), .skip(skip), .base(base),
        .idx(idx), .loop_end(loop_end));

    function automatic int sz(int d);
        return d == 0 ? int'(size_x) : d == 1 ? int'(size_y) : int'(size_z);
    endfunction

    function automatic bit is_last(int d);
        return invert[d] ? (mc[d] == 0) : (mc[d] == sz(d) - 1);
    endfunction

    function automatic int first_val(int d);
        return invert[d] ? sz(d) - 1 : 0;
    endfunction

    // Expected offset from requirements R3..R6.
    function automatic int exp_idx();
        int ords[3];
        int sum = 0, mult = 1;
        ords[0] = order0; ords[1] = order1; ords[2] = order2;
        for (int p = 0; p < 3; p++) begin
            int a = (ords[p] == 3) ? 0 : ords[p];
            if (int'(skip) == p + 1) continue;
            sum += mc[a] * mult;
            mult *= sz(a);
        end
        return (sum + int'(base)) % (1 << IDX_W);
    endfunction

    // Reference counter model (R1, R2, R8, R9, R10, R11, R12).
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 3; d++) mc[d] <= 0;
        end else if (restart) begin
            for (int d = 0; d < 3; d++) mc[d] <= first_val(d);
        end else if (step) begin
            bit go;
            go = 1;
            for (int d = 0; d < 3; d++) begin
                if (go) mc[d] <= is_last(d) ? first_val(d)
                               : (invert[d] ? mc[d] - 1 : mc[d] + 1);
                go = go && is_last(d);
            end
        end
    end

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        int e;
        logic [2:0] el;
        e = exp_idx();
        el = {is_last(0) && is_last(1) && is_last(2), is_last(0) && is_last(1), is_last(0)};
        checks++;
        if (int'(idx) != e) begin
            failures++;
            $display("FAIL %s idx actual=%0d expected=%0d", tag, idx, e);
        end
        checks++;
        if (loop_end != el) begin
            failures++;
            $display("FAIL R7 loop_end actual=%b expected=%b", loop_end, el);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cfg(int sx, int sy, int sz_, int o0, int o1, int o2,
                       int inv, int sk, int bs, string t);
        @(negedge clk); #1;
        size_x = DIM_W'(sx); size_y = DIM_W'(sy); size_z = DIM_W'(sz_);
        order0 = 2'(o0); order1 = 2'(o1); order2 = 2'(o2);
        invert = 3'(inv); skip = 2'(sk); base = BASE_W'(bs);
        restart = 1; step = 0; tag = t;
    endtask

    task automatic run(int n, int dens);
        repeat (n) begin
            @(negedge clk); #1;
            restart = 0;
            step = ($urandom % 100) < dens;
        end
    endtask

    initial begin
        // R12: reset state, idx must equal base
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        run(2, 0);
        cfg(3, 4, 1, 0, 1, 2, 0, 0, 0, "R1");    run(30, 100);
        cfg(3, 4, 1, 1, 0, 2, 0, 0, 0, "R3");    run(30, 100);
        cfg(3, 4, 2, 3, 2, 1, 0, 0, 0, "R3");    run(30, 100);
        cfg(5, 3, 1, 1, 0, 2, 3, 0, 0, "R2");    run(40, 100);
        cfg(2, 3, 4, 2, 0, 1, 4, 0, 0, "R4");    run(50, 100);
        for (int k = 1; k < 4; k++) begin
            cfg(2, 3, 4, 0, 1, 2, 0, k, 0, "R5"); run(30, 100);
        end
        cfg(4, 2, 3, 1, 2, 0, 2, 0, 200, "R6");  run(40, 100);
        cfg(5, 3, 2, 0, 1, 2, 0, 0, 250, "R6");  run(35, 100);
        cfg(1, 5, 1, 0, 1, 2, 0, 0, 0, "R9");    run(12, 100);
        cfg(64, 1, 1, 0, 1, 2, 1, 0, 0, "R9");   run(70, 100);
        cfg(1, 1, 1, 0, 1, 2, 7, 0, 3, "R9");    run(5, 100);
        cfg(3, 5, 7, 2, 1, 0, 5, 0, 0, "R8");    run(320, 100);
        cfg(4, 3, 2, 1, 0, 2, 6, 0, 0, "R10");   run(200, 40);
        cfg(3, 3, 2, 0, 2, 1, 1, 0, 0, "R11");
        repeat (5) begin
            run(7, 100);
            @(negedge clk); #1; restart = 1; step = 1;   // R11: restart beats step
        end
        run(10, 100);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule